// File: doc/BRIEF.md
# Indirect Control/Status Register File for a Network Controller

This block is the host-facing register file of a network controller. The host reaches it through one narrow port with two address slots. The pointer slot holds a register index, and the data slot reads or writes the register that the index selects. The index stays in effect until the host writes the pointer slot again, so a driver can set it once and then poll or update the same register many times.

There are four internal registers. Register 0 carries run control and status. Its command bits are init, start, stop and transmit-demand, and each one issues a single-cycle pulse toward the controller core. It also holds an interrupt enable, a halted indication, seven event flags that are cleared by writing 1, an error summary and an interrupt summary. Registers 1 and 2 hold the low and high parts of the address of the initialisation block in memory. Register 3 holds the bus-mode bits, such as byte swapping and address-latch control. The core can hold off a host access with a ready input, and every access ends with a one-cycle acknowledge.

Top module: `netctl_csr_file`

## Requirements
- R1: A write to the pointer slot (hostSel=0) stores hostWdata[1:0] as the register index. A read of the pointer slot returns the index zero-extended to 16 bits. Data-slot accesses (hostSel=1) go to the indexed register.
- R2: An access is taken on a clock edge where the block is idle, hostReq=1 and coreReady=1. hostAck is high for exactly the one cycle after that edge, and read data is valid on hostRdata while hostAck is high. While coreReady=0, no access is taken and hostAck stays low.
- R3: Register 1 holds initAddr[15:0]. Register 2 holds initAddr[ADDR_HI_W+15:16] in its low ADDR_HI_W bits. Register 3 holds busMode in its low MODE_W bits. Bits above those fields are dropped on a write and read back as 0.
- R4: Writes to registers 1, 2 and 3 are ignored unless the halted bit (register 0 bit 6) is 1. The block comes out of reset halted.
- R5: The register 0 layout is as follows. Bits 0, 1, 2 and 3 are the init, start, stop and transmit-demand commands, and they read 0. Bit 4 is the interrupt enable. Bit 5 is the interrupt summary. Bit 6 is halted. Bits 7 to 13 are the flags init-done, receive, transmit, memory error, missed frame, collision error and babble. Bit 14 reads 0. Bit 15 is the error summary. Out of reset it reads 0x0040.
- R6: Writing 1 to command bit 0, 1, 2 or 3 of register 0 raises cmdInit, cmdStart, cmdStop or cmdTdmd for the single cycle in which hostAck is high. When bit 2 (stop) is written, the cmdInit and cmdStart pulses are suppressed.
- R7: Writing stop sets halted and clears the interrupt enable. Writing init or start without stop clears halted. A memory-error event (coreEvent[7]) sets halted, and this takes priority over a host write in the same cycle.
- R8: The events coreEvent[0,2,3,7,6,5,4] set the flags init-done, receive, transmit, memory error, missed frame, collision error and babble. Writing 1 to a flag bit clears that flag and writing 0 leaves it unchanged. When an event arrives in the same cycle as a clear of its flag, the flag stays set.
- R9: An initialisation failure (coreEvent[1]) sets the memory-error flag (bit 10). The error summary bit 15 is the OR of bits 10 to 13.
- R10: The interrupt summary bit 5 is the OR of flag bits 7 to 13. Writing 1 to bit 4 sets the interrupt enable and writing 0 leaves it unchanged. irq equals bit 5 ANDed with bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostReq | input | 1 | Host access request, held until hostAck |
| hostSel | input | 1 | 0 selects the pointer slot, 1 selects the data slot |
| hostWr | input | 1 | 1 for a write, 0 for a read |
| hostWdata | input | 16 | Host write data |
| hostAck | output | 1 | One-cycle access acknowledge |
| hostRdata | output | 16 | Read data, valid with hostAck |
| coreReady | input | 1 | Core allows an access to be taken |
| coreEvent | input | 8 | Single-cycle event strobes from the core |
| cmdInit | output | 1 | Initialise pulse |
| cmdStart | output | 1 | Start pulse |
| cmdStop | output | 1 | Stop pulse |
| cmdTdmd | output | 1 | Transmit-demand pulse |
| initAddr | output | ADDR_HI_W+16 | Initialisation block address |
| busMode | output | MODE_W | Bus-mode control bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with ADDR_HI_W=6 and MODE_W=3. With those values, all-ones writes to registers 2 and 3 show the dropped upper bits on readback, and a 22-bit initAddr is compared as a whole. Directed sequences cover the corner cases that matter most: configuration writes while running, a clear colliding with a new event, stop written together with start and init, a memory error halting the core, and ready stalls of several cycles. A randomized phase then mixes accesses, event bursts and ready stalls against the cycle model.

// File: rtl/netctl_csr_pkg.sv
package netctl_csr_pkg;
  localparam int HOST_W   = 16;
  localparam int NUM_REGS = 4;
  localparam int PTR_W    = $clog2(NUM_REGS);
  localparam int EVT_W    = 8;
  localparam int FLAG_W   = 7;

  // register 0 bit positions
  localparam int C0_INIT    = 0;
  localparam int C0_START   = 1;
  localparam int C0_STOP    = 2;
  localparam int C0_TDMD    = 3;
  localparam int C0_INTEN   = 4;
  localparam int C0_SUM     = 5;
  localparam int C0_HALT    = 6;
  localparam int C0_FLAG_LO = 7;
  localparam int C0_ERR     = 15;

  // flag indices inside the flag group
  localparam int F_IDONE = 0;
  localparam int F_RX    = 1;
  localparam int F_TX    = 2;
  localparam int F_MEM   = 3;
  localparam int F_MISS  = 4;
  localparam int F_COLL  = 5;
  localparam int F_BABL  = 6;

  // core event strobe indices
  localparam int EV_IDONE = 0;
  localparam int EV_IFAIL = 1;
  localparam int EV_RX    = 2;
  localparam int EV_TX    = 3;
  localparam int EV_BABL  = 4;
  localparam int EV_COLL  = 5;
  localparam int EV_MISS  = 6;
  localparam int EV_MEM   = 7;

  typedef enum logic {S_IDLE, S_DONE} acc_state_t;

  typedef struct packed {
    logic                ptrWr;
    logic                ptrRd;
    logic [NUM_REGS-1:0] regWr;
    logic [NUM_REGS-1:0] regRd;
    logic [HOST_W-1:0]   wdata;
  } csr_strobe_t;
endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import netctl_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hostReq,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [HOST_W-1:0] hostWdata,
  input  logic              coreReady,
  input  logic [PTR_W-1:0]  curPtr,
  output csr_strobe_t       strobe,
  output logic              hostAck
);
  acc_state_t state;
  logic take;

  assign take = (state == S_IDLE) && hostReq && coreReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      hostAck <= 1'b0;
    end else begin
      state   <= take ? S_DONE : S_IDLE;
      hostAck <= take;
    end
  end

  always_comb begin
    strobe.ptrWr = take && !hostSel && hostWr;
    strobe.ptrRd = take && !hostSel && !hostWr;
    strobe.wdata = hostWdata;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign strobe.regWr[g] = take && hostSel && hostWr  && (curPtr == PTR_W'(g));
    assign strobe.regRd[g] = take && hostSel && !hostWr && (curPtr == PTR_W'(g));
  end

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    hostAck |=> !hostAck);
  // R2
  no_take_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    !coreReady |=> !hostAck);
  // R1
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.regWr, strobe.regRd, strobe.ptrWr, strobe.ptrRd}));
endmodule

// File: rtl/csr_datapath.sv
module csr_datapath
  import netctl_csr_pkg::*;
#(
  parameter int ADDR_HI_W = 8,
  parameter int MODE_W    = 3
)(
  input  logic                 clk,
  input  logic                 rst,
  input  csr_strobe_t          strobe,
  input  logic [EVT_W-1:0]     coreEvent,
  output logic [PTR_W-1:0]     curPtr,
  output logic [HOST_W-1:0]    hostRdata,
  output logic [ADDR_HI_W+15:0] initAddr,
  output logic [MODE_W-1:0]    busMode,
  output logic                 irq,
  output logic                 cmdInit,
  output logic                 cmdStart,
  output logic                 cmdStop,
  output logic                 cmdTdmd
);
  logic [PTR_W-1:0]     ptrQ;
  logic                 haltQ, intEnQ;
  logic [FLAG_W-1:0]    flagQ, flagSet, flagClr;
  logic [HOST_W-1:0]    addrLoQ;
  logic [ADDR_HI_W-1:0] addrHiQ;
  logic [MODE_W-1:0]    modeQ;
  logic [HOST_W-1:0]    wd, csr0Val;
  logic                 wr0, stopReq, goReq, errBit, sumBit;
  logic [HOST_W-1:0]    regView [NUM_REGS];
  logic                 unusedWd;

  assign wd       = strobe.wdata;
  assign unusedWd = ^wd;
  assign wr0      = strobe.regWr[0];
  assign stopReq  = wr0 && wd[C0_STOP];
  assign goReq    = wr0 && (wd[C0_INIT] || wd[C0_START]) && !wd[C0_STOP];
  assign flagClr  = wr0 ? wd[C0_FLAG_LO +: FLAG_W] : '0;

  always_comb begin
    flagSet          = '0;
    flagSet[F_IDONE] = coreEvent[EV_IDONE];
    flagSet[F_RX]    = coreEvent[EV_RX];
    flagSet[F_TX]    = coreEvent[EV_TX];
    flagSet[F_MEM]   = coreEvent[EV_MEM] || coreEvent[EV_IFAIL];
    flagSet[F_MISS]  = coreEvent[EV_MISS];
    flagSet[F_COLL]  = coreEvent[EV_COLL];
    flagSet[F_BABL]  = coreEvent[EV_BABL];
  end

  assign errBit = flagQ[F_MEM] || flagQ[F_MISS] || flagQ[F_COLL] || flagQ[F_BABL];
  assign sumBit = |flagQ;

  always_comb begin
    csr0Val                        = '0;
    csr0Val[C0_INTEN]              = intEnQ;
    csr0Val[C0_SUM]                = sumBit;
    csr0Val[C0_HALT]               = haltQ;
    csr0Val[C0_FLAG_LO +: FLAG_W]  = flagQ;
    csr0Val[C0_ERR]                = errBit;
  end

  assign regView[0] = csr0Val;
  assign regView[1] = addrLoQ;
  assign regView[2] = HOST_W'(addrHiQ);
  assign regView[3] = HOST_W'(modeQ);

  // run control and event flags
  always_ff @(posedge clk) begin
    if (rst) begin
      haltQ  <= 1'b1;
      intEnQ <= 1'b0;
      flagQ  <= '0;
    end else begin
      flagQ <= (flagQ & ~flagClr) | flagSet;
      if (coreEvent[EV_MEM] || stopReq) haltQ <= 1'b1;
      else if (goReq)                   haltQ <= 1'b0;
      if (stopReq)                      intEnQ <= 1'b0;
      else if (wr0 && wd[C0_INTEN])     intEnQ <= 1'b1;
    end
  end

  // command pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      cmdInit  <= 1'b0;
      cmdStart <= 1'b0;
      cmdStop  <= 1'b0;
      cmdTdmd  <= 1'b0;
    end else begin
      cmdInit  <= wr0 && wd[C0_INIT]  && !wd[C0_STOP];
      cmdStart <= wr0 && wd[C0_START] && !wd[C0_STOP];
      cmdStop  <= stopReq;
      cmdTdmd  <= wr0 && wd[C0_TDMD];
    end
  end

  // pointer and configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ptrQ    <= '0;
      addrLoQ <= '0;
      addrHiQ <= '0;
      modeQ   <= '0;
    end else begin
      if (strobe.ptrWr)               ptrQ    <= wd[PTR_W-1:0];
      if (strobe.regWr[1] && haltQ)   addrLoQ <= wd;
      if (strobe.regWr[2] && haltQ)   addrHiQ <= wd[ADDR_HI_W-1:0];
      if (strobe.regWr[3] && haltQ)   modeQ   <= wd[MODE_W-1:0];
    end
  end

  // read data capture
  always_ff @(posedge clk) begin
    if (rst) begin
      hostRdata <= '0;
    end else if (strobe.ptrRd) begin
      hostRdata <= HOST_W'(ptrQ);
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (strobe.regRd[i]) hostRdata <= regView[i];
    end
  end

  assign curPtr   = ptrQ;
  assign initAddr = {addrHiQ, addrLoQ};
  assign busMode  = modeQ;
  assign irq      = sumBit && intEnQ;

  // R6
  stop_priority_chk: assert property (@(posedge clk) disable iff (rst)
    cmdStop |-> (!cmdStart && !cmdInit));
  // R7
  stop_masks_irq_chk: assert property (@(posedge clk) disable iff (rst)
    cmdStop |-> !irq);
  // R4
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !haltQ |=> ($stable(initAddr) && $stable(busMode)));
  // R8
  w1c_only_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(flagQ) & ~flagQ)) |-> $past(strobe.regWr[0]));
  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdInit || cmdStart || cmdStop || cmdTdmd) |=> !(cmdInit || cmdStart || cmdStop || cmdTdmd));
endmodule

// File: rtl/netctl_csr_file.sv
module netctl_csr_file
  import netctl_csr_pkg::*;
#(
  parameter int ADDR_HI_W = 8,
  parameter int MODE_W    = 3
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hostReq,
  input  logic                  hostSel,
  input  logic                  hostWr,
  input  logic [15:0]           hostWdata,
  output logic                  hostAck,
  output logic [15:0]           hostRdata,
  input  logic                  coreReady,
  input  logic [7:0]            coreEvent,
  output logic                  cmdInit,
  output logic                  cmdStart,
  output logic                  cmdStop,
  output logic                  cmdTdmd,
  output logic [ADDR_HI_W+15:0] initAddr,
  output logic [MODE_W-1:0]     busMode,
  output logic                  irq
);
  csr_strobe_t      strobe;
  logic [PTR_W-1:0] curPtr;

  csr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .hostReq(hostReq), .hostSel(hostSel), .hostWr(hostWr),
    .hostWdata(hostWdata), .coreReady(coreReady), .curPtr(curPtr),
    .strobe(strobe), .hostAck(hostAck)
  );

  csr_datapath #(.ADDR_HI_W(ADDR_HI_W), .MODE_W(MODE_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .coreEvent(coreEvent),
    .curPtr(curPtr), .hostRdata(hostRdata), .initAddr(initAddr), .busMode(busMode),
    .irq(irq), .cmdInit(cmdInit), .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdTdmd(cmdTdmd)
  );
endmodule

// File: tb/netctl_csr_file_bench.sv
module netctl_csr_file_bench;
  localparam int HI_W = 6;
  localparam int MD_W = 3;

  logic clk = 0, rst = 1;
  logic hostReq = 0, hostSel = 0, hostWr = 0, coreReady = 1;
  logic [15:0] hostWdata = 0;
  logic [7:0]  coreEvent = 0;
  logic hostAck, cmdInit, cmdStart, cmdStop, cmdTdmd, irq;
  logic [15:0] hostRdata;
  logic [HI_W+15:0] initAddr;
  logic [MD_W-1:0] busMode;

  netctl_csr_file #(.ADDR_HI_W(HI_W), .MODE_W(MD_W)) u_netctl_csr_file (
    .clk(clk), .rst(rst), .hostReq(hostReq), .hostSel(hostSel), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostAck(hostAck), .hostRdata(hostRdata),
    .coreReady(coreReady), .coreEvent(coreEvent), .cmdInit(cmdInit), .cmdStart(cmdStart),
    .cmdStop(cmdStop), .cmdTdmd(cmdTdmd), .initAddr(initAddr), .busMode(busMode), .irq(irq)
  );

  always #4 clk = ~clk;

  int nChecks = 0, nFail = 0;
  logic [15:0] lastRd;
  logic [3:0]  lastCmd;
  bit randMode = 0;
  int cyc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [1:0]  mPtr;
  bit          mHalt, mIntEn;
  bit          mFlag [7];      // idone, rx, tx, mem, miss, coll, babble
  logic [15:0] mLo;
  logic [HI_W-1:0] mHi;
  logic [MD_W-1:0] mMode;
  int          mPhase;
  bit          expAck, expRdValid;
  logic [15:0] expRd;
  logic [3:0]  expCmd;          // {tdmd, stop, start, init}

  function automatic logic [15:0] modelReg0();
    logic [15:0] v = 0;
    bit anyF = 0;
    for (int i = 0; i < 7; i++) begin
      v[7+i] = mFlag[i];
      anyF |= mFlag[i];
    end
    v[4]  = mIntEn;
    v[5]  = anyF;
    v[6]  = mHalt;
    v[15] = mFlag[3] | mFlag[4] | mFlag[5] | mFlag[6];
    return v;
  endfunction

  function automatic bit modelIrq();
    bit anyF = 0;
    for (int i = 0; i < 7; i++) anyF |= mFlag[i];
    return anyF & mIntEn;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mPtr = 0; mHalt = 1; mIntEn = 0; mLo = 0; mHi = 0; mMode = 0;
      for (int i = 0; i < 7; i++) mFlag[i] = 0;
      mPhase = 0; expAck = 0; expRdValid = 0; expRd = 0; expCmd = 0;
    end else begin
      logic [15:0] r0;
      bit take;
      r0 = modelReg0();
      take = (mPhase == 0) && hostReq && coreReady;
      expAck = 0; expRdValid = 0; expCmd = 0;
      if (mPhase == 1) mPhase = 0;
      if (take) begin
        mPhase = 1;
        expAck = 1;
        if (!hostSel) begin
          if (hostWr) mPtr = hostWdata[1:0];
          else begin expRd = {14'b0, mPtr}; expRdValid = 1; end
        end else if (!hostWr) begin
          expRdValid = 1;
          case (mPtr)
            2'd0: expRd = r0;
            2'd1: expRd = mLo;
            2'd2: expRd = 16'(mHi);
            default: expRd = 16'(mMode);
          endcase
        end else begin
          case (mPtr)
            2'd0: begin
              for (int i = 0; i < 7; i++) if (hostWdata[7+i]) mFlag[i] = 0;
              if (hostWdata[2]) begin
                mHalt = 1; mIntEn = 0; expCmd[2] = 1;
              end else begin
                if (hostWdata[4]) mIntEn = 1;
                if (hostWdata[0] || hostWdata[1]) mHalt = 0;
                expCmd[0] = hostWdata[0];
                expCmd[1] = hostWdata[1];
              end
              expCmd[3] = hostWdata[3];
            end
            2'd1: if (r0[6]) mLo = hostWdata;
            2'd2: if (r0[6]) mHi = hostWdata[HI_W-1:0];
            default: if (r0[6]) mMode = hostWdata[MD_W-1:0];
          endcase
        end
      end
      if (coreEvent[0]) mFlag[0] = 1;
      if (coreEvent[2]) mFlag[1] = 1;
      if (coreEvent[3]) mFlag[2] = 1;
      if (coreEvent[7] || coreEvent[1]) mFlag[3] = 1;
      if (coreEvent[6]) mFlag[4] = 1;
      if (coreEvent[5]) mFlag[5] = 1;
      if (coreEvent[4]) mFlag[6] = 1;
      if (coreEvent[7]) mHalt = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2", hostAck, expAck, "ack per cycle");
      if (expAck && expRdValid) chk("R5", hostRdata, expRd, "read data per cycle");
      chk("R6", {cmdTdmd, cmdStop, cmdStart, cmdInit}, expCmd, "command pulses per cycle");
      chk("R10", irq, modelIrq(), "irq per cycle");
      chk("R3", initAddr, {mHi, mLo}, "initAddr per cycle");
      chk("R3", busMode, mMode, "busMode per cycle");
    end
  end

  // ---------------- stimulus ----------------
  task automatic access(input bit sel, input bit wr, input logic [15:0] d,
                        input logic [7:0] ev = 8'h00, input int stall = 0);
    int n = 0;
    @(negedge clk);
    hostReq = 1; hostSel = sel; hostWr = wr; hostWdata = d; coreEvent = ev;
    if (stall > 0) coreReady = 0;
    forever begin
      @(negedge clk);
      coreEvent = 0;
      if (hostAck) break;
      if (stall > 0) begin
        chk("R2", hostAck, 0, "no ack while stalled");
        n++;
        if (n >= stall) coreReady = 1;
      end else if (randMode) begin
        coreReady = (cyc % 3) != 0;
      end
    end
    lastRd  = hostRdata;
    lastCmd = {cmdTdmd, cmdStop, cmdStart, cmdInit};
    hostReq = 0;
    coreReady = 1;
  endtask

  task automatic evt(input logic [7:0] ev);
    @(negedge clk); coreEvent = ev;
    @(negedge clk); coreEvent = 0;
  endtask

  task automatic rd0(input string req, input logic [15:0] exp);
    access(1, 0, 16'h0);
    chk(req, lastRd, exp, "register 0 readback");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFail++;
    $display("FAIL R2 watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int seed = 32'h1ACE5;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10", irq, 0, "irq after reset");
    chk("R3", initAddr, 0, "initAddr after reset");

    // R5 / R4: reset value of register 0, halted
    rd0("R5", 16'h0040);

    // R1: pointer port
    access(0, 1, 16'hFFFF);
    access(0, 0, 16'h0);
    chk("R1", lastRd, 16'h0003, "pointer readback");

    // R3: configuration writes while halted, truncation
    access(1, 1, 16'hFFFF);
    access(1, 0, 16'h0);
    chk("R3", lastRd, 16'h0007, "mode readback truncated");
    access(0, 1, 16'h0001);
    access(1, 1, 16'hBEEF);
    access(0, 1, 16'h0002);
    access(1, 1, 16'hFFAB);
    access(1, 0, 16'h0);
    chk("R3", lastRd, 16'h002B, "addr high readback truncated");
    chk("R3", initAddr, {6'h2B, 16'hBEEF}, "initAddr value");

    // R2: stalled access
    access(0, 1, 16'h0001);
    access(1, 0, 16'h0, 8'h00, 5);
    chk("R2", lastRd, 16'hBEEF, "read after stall");

    // R7 / R4: start leaves halted, config locked
    access(0, 1, 16'h0000);
    access(1, 1, 16'h0002);
    chk("R6", lastCmd, 4'b0010, "start pulse");
    rd0("R7", 16'h0000);
    access(0, 1, 16'h0001);
    access(1, 1, 16'h1234);
    access(1, 0, 16'h0);
    chk("R4", lastRd, 16'hBEEF, "write ignored while running");
    access(0, 1, 16'h0000);

    // R10 / R8: interrupt enable and receive flag
    access(1, 1, 16'h0010);
    evt(8'h04);
    @(negedge clk);
    chk("R10", irq, 1, "irq with rx flag and enable");
    rd0("R8", 16'h0130);
    access(1, 1, 16'h0000);
    rd0("R8", 16'h0130);

    // R8: clear rx while tx event; clear tx while tx event (set wins)
    access(1, 1, 16'h0100, 8'h08);
    rd0("R8", 16'h0230);
    access(1, 1, 16'h0200, 8'h08);
    rd0("R8", 16'h0230);
    access(1, 1, 16'h0200);
    rd0("R8", 16'h0010);
    chk("R10", irq, 0, "irq after all flags cleared");

    // R9: babble drives error summary; init failure sets memory error
    evt(8'h10);
    rd0("R9", 16'hA030);
    access(1, 1, 16'h2000);
    evt(8'h02);
    rd0("R9", 16'h8430);
    access(1, 1, 16'h0400);

    // R7: memory error halts, start resumes
    evt(8'h80);
    rd0("R7", 16'h8470);
    access(1, 1, 16'h0402);
    rd0("R7", 16'h0010);

    // R8: init-done flag
    evt(8'h01);
    rd0("R8", 16'h00B0);
    access(1, 1, 16'h0080);

    // R6 / R7: stop together with init and start
    access(1, 1, 16'h0007);
    chk("R6", lastCmd, 4'b0100, "stop wins over init and start");
    chk("R7", irq, 0, "irq after stop");
    rd0("R7", 16'h0040);

    // R6: transmit demand and init alone
    access(1, 1, 16'h0008);
    chk("R6", lastCmd, 4'b1000, "tdmd pulse");
    access(1, 1, 16'h0001);
    chk("R6", lastCmd, 4'b0001, "init pulse");
    rd0("R7", 16'h0000);

    // R10: flags without enable give no irq
    evt(8'h60);
    @(negedge clk);
    chk("R10", irq, 0, "irq masked by enable");
    rd0("R9", 16'h9820);
    access(1, 1, 16'h0010);
    @(negedge clk);
    chk("R10", irq, 1, "irq once enabled");
    access(1, 1, 16'h1800);

    // randomized phase against the model
    randMode = 1;
    for (int k = 0; k < 400; k++) begin
      seed = seed * 1103515245 + 12345;
      if (seed[20:19] == 2'b00)
        evt(seed[15:8]);
      else if (seed[22:21] == 2'b00)
        access(0, seed[3], {14'b0, seed[5:4]});
      else
        access(1, seed[3], seed[28:13], seed[9] ? seed[17:10] : 8'h00);
    end
    randMode = 0;

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule